// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

This block turns a raw "both alert tones present" flag into a steering output that has been qualified by guard times. The tone filters and the detector that compares them are outside the block. The raw flag is first passed through a two-flop synchronizer. A single counter, advanced by a one-cycle millisecond tick, then measures how long the synchronized flag has disagreed with the current steering state.

The qualified output rises only after the flag has stayed high for a programmable tone-present guard time. Once it is high, it falls only after the flag has stayed low for a separate, programmable tone-absent guard time. This second guard hides short detection dropouts. The two guard lengths come in on their own configuration ports, in milliseconds. A typical on-hook profile uses a present guard of 20 ms or more and an absent guard of 15 to 17 ms, with the present guard longer than the absent guard.

A disable input hides the result from the rest of the system while qualification carries on inside the block. A power-down input clears everything back to the tone-absent condition. The block also combines three sources into an active-low interrupt request: the qualified output, an active-low ring/reversal trigger and an active-low data-ready flag.

Top module: `alert_guard_qual`

## Requirements
- R1: `std_q` rises only after the synchronized alert flag has been high during `present_ms` consecutive ms ticks. If the flag falls back before the count is reached, `std_q` stays low. `std_q` changes on the clock edge that samples the qualifying tick.
- R2: While `std_q` is high, it falls only after the synchronized flag has been low during `absent_ms` consecutive ms ticks. A dropout shorter than that leaves `std_q` high.
- R3: The guard count restarts from zero whenever the synchronized flag returns to the level that matches the current guard state. An interrupted qualification or release therefore needs the full guard length again.
- R4: `present_ms` and `absent_ms` are independent, and each applies only in its own direction. A value of 0 acts as 1 tick.
- R5: While `det_disable` is 1, `std_q` is 0, but the guard state keeps tracking. If a qualified tone is still present when `det_disable` returns to 0, `std_q` is 1 in that same cycle.
- R6: While `pwr_dn` is 1, `std_q` and `est_q` are 0 and the guard state is forced to tone-absent. After exit, a tone needs the full `present_ms` again.
- R7: `irq_n` is 0 whenever `std_q` is 1, `trig_n` is 0 or `rdy_n` is 0. It is 1 only when all three are inactive.
- R8: `est_q` follows `est_raw` two clock cycles later. A level driven between edges shows up after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| est_raw | input | 1 | Raw dual-tone-present flag from the detector |
| det_disable | input | 1 | 1 holds the qualified output low |
| pwr_dn | input | 1 | 1 forces the guard state to tone-absent |
| present_ms | input | GT_W | Tone-present guard time, in ms ticks |
| absent_ms | input | GT_W | Tone-absent guard time, in ms ticks |
| trig_n | input | 1 | Active-low ring/line-reversal trigger |
| rdy_n | input | 1 | Active-low data-ready flag |
| est_q | output | 1 | Synchronized raw flag, low in power-down |
| std_q | output | 1 | Guard-time-qualified tone output |
| irq_n | output | 1 | Active-low combined interrupt request |

## Verification
On every cycle, the assertions check four things. The guard state can change only on a tick. It cannot change while the flag agrees with it. Power-down leaves it tone-absent on the next edge. The interrupt is low whenever the qualified output is high.

Other behaviours need a whole stimulus sequence and can only be shown by the bench scenarios:
- the exact tick count at which the output rises or falls;
- the restart of the count after an interrupted guard;
- the zero-means-one rule;
- requalification after power-down;
- the immediate release when the disable is lifted.

// File: rtl/agq_pkg.sv
package agq_pkg;
  typedef enum logic {
    GS_ABSENT  = 1'b0,
    GS_PRESENT = 1'b1
  } guard_st_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/agq_sync.sv
module agq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chain[0] <= 1'b0;
    else if (clr) chain[0] <= 1'b0;
    else          chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   chain[i] <= 1'b0;
      else if (clr) chain[i] <= 1'b0;
      else          chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/agq_guard.sv
module agq_guard
  import agq_pkg::*;
#(
  parameter int unsigned GT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            pd,
  input  logic            flag,
  input  logic [GT_W-1:0] gp,
  input  logic [GT_W-1:0] ga,
  output guard_st_e       state
);
  localparam int unsigned CW = GT_W + 1;

  logic [GT_W-1:0] cnt;
  logic [GT_W-1:0] lim_sel;
  logic [CW-1:0]   lim_eff;
  logic [CW-1:0]   cnt_nxt;
  logic            mismatch;
  logic            reach;

  always_comb begin
    lim_sel  = (state == GS_PRESENT) ? ga : gp;
    lim_eff  = (lim_sel == '0) ? CW'(1) : {1'b0, lim_sel};
    cnt_nxt  = {1'b0, cnt} + CW'(1);
    mismatch = flag != (state == GS_PRESENT);
    reach    = cnt_nxt >= lim_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GS_ABSENT;
      cnt   <= '0;
    end else if (pd) begin
      state <= GS_ABSENT;
      cnt   <= '0;
    end else if (!mismatch) begin
      cnt <= '0;
    end else if (tick) begin
      if (reach) begin
        state <= (state == GS_PRESENT) ? GS_ABSENT : GS_PRESENT;
        cnt   <= '0;
      end else begin
        cnt <= cnt_nxt[GT_W-1:0];
      end
    end
  end

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_PRESENT && $past(state) == GS_ABSENT) |-> $past(tick)); // R1
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_ABSENT && $past(state) == GS_PRESENT && !$past(pd)) |-> $past(tick)); // R2
  AST_HOLD_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd && !mismatch) |=> $stable(state)); // R3
  AST_PD_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (state == GS_ABSENT)); // R6
endmodule

// File: rtl/agq_irq.sv
module agq_irq (
  input  logic std_i,
  input  logic trig_n,
  input  logic rdy_n,
  output logic irq_n
);
  always_comb irq_n = !(std_i || !trig_n || !rdy_n);
endmodule

// File: rtl/alert_guard_qual.sv
module alert_guard_qual
  import agq_pkg::*;
#(
  parameter int unsigned GT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic            est_raw,
  input  logic            det_disable,
  input  logic            pwr_dn,
  input  logic [GT_W-1:0] present_ms,
  input  logic [GT_W-1:0] absent_ms,
  input  logic            trig_n,
  input  logic            rdy_n,
  output logic            est_q,
  output logic            std_q,
  output logic            irq_n
);
  logic      est_s;
  guard_st_e gstate;

  agq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .d(est_raw), .q(est_s)
  );

  agq_guard #(.GT_W(GT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .pd(pwr_dn), .flag(est_s),
    .gp(present_ms), .ga(absent_ms), .state(gstate)
  );

  always_comb begin
    est_q = est_s && !pwr_dn;
    std_q = (gstate == GS_PRESENT) && !det_disable && !pwr_dn;
  end

  agq_irq u_irq (.std_i(std_q), .trig_n(trig_n), .rdy_n(rdy_n), .irq_n(irq_n));

  AST_IRQ_ON_STD: assert property (@(posedge clk) disable iff (!rst_n)
    std_q |-> !irq_n); // R7
endmodule

// File: tb/tb_alert_guard_qual.sv
`timescale 1ns/1ps
module tb_alert_guard_qual;
  localparam int GT_W = 8;
  logic clk = 0, rst_n = 0, ms_tick = 0, est_raw = 0, det_disable = 0, pwr_dn = 0;
  logic [GT_W-1:0] present_ms = 8'd5, absent_ms = 8'd3;
  logic trig_n = 1, rdy_n = 1;
  logic est_q, std_q, irq_n;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alert_guard_qual #(.GT_W(GT_W)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .est_raw(est_raw),
    .det_disable(det_disable), .pwr_dn(pwr_dn), .present_ms(present_ms),
    .absent_ms(absent_ms), .trig_n(trig_n), .rdy_n(rdy_n),
    .est_q(est_q), .std_q(std_q), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1;
      @(negedge clk) ms_tick = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic set_est(input logic v);
    @(negedge clk) est_raw = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset std", std_q, 0);
    check("R8 reset est", est_q, 0);
    check("R7 reset irq", irq_n, 1);
  endtask

  task automatic t_sync;
    @(negedge clk) est_raw = 1;
    @(negedge clk) check("R8 one edge", est_q, 0);
    @(negedge clk) check("R8 two edges", est_q, 1);
    est_raw = 0;
    repeat (2) @(negedge clk);
    check("R8 back low", est_q, 0);
  endtask

  task automatic t_short;
    set_est(1); tick(4);
    check("R1 short pulse", std_q, 0);
    set_est(0); tick(2);
    check("R1 short rejected", std_q, 0);
  endtask

  task automatic t_qualify;
    set_est(1); tick(4);
    check("R1 before guard", std_q, 0);
    tick(1);
    check("R1 at guard", std_q, 1);
    check("R7 irq from std", irq_n, 0);
  endtask

  task automatic t_dropout;
    set_est(0); tick(2);
    check("R2 dropout masked", std_q, 1);
    set_est(1);
    set_est(0); tick(2);
    check("R3 absent restart", std_q, 1);
    tick(1);
    check("R2 release", std_q, 0);
    check("R7 irq idle", irq_n, 1);
  endtask

  task automatic t_restart;
    set_est(1); tick(3);
    set_est(0);
    set_est(1); tick(4);
    check("R3 present restart", std_q, 0);
    tick(1);
    check("R3 requalified", std_q, 1);
    set_est(0); tick(3);
    check("R2 cleanup", std_q, 0);
  endtask

  task automatic t_cfg;
    present_ms = 0; absent_ms = 0;
    set_est(1); tick(1);
    check("R4 zero present", std_q, 1);
    set_est(0); tick(1);
    check("R4 zero absent", std_q, 0);
    present_ms = 2; absent_ms = 6;
    set_est(1); tick(2);
    check("R4 short present", std_q, 1);
    set_est(0); tick(5);
    check("R4 long absent hold", std_q, 1);
    tick(1);
    check("R4 long absent end", std_q, 0);
    present_ms = 5; absent_ms = 3;
  endtask

  task automatic t_disable;
    @(negedge clk) det_disable = 1;
    set_est(1); tick(5);
    check("R5 held low", std_q, 0);
    check("R5 no irq", irq_n, 1);
    @(negedge clk) det_disable = 0;
    #1 check("R5 release", std_q, 1);
    set_est(0); tick(3);
    check("R5 cleanup", std_q, 0);
  endtask

  task automatic t_pd;
    set_est(1); tick(5);
    check("R6 pre", std_q, 1);
    @(negedge clk) pwr_dn = 1;
    #1 check("R6 std low", std_q, 0);
    check("R6 est low", est_q, 0);
    tick(2);
    @(negedge clk) pwr_dn = 0;
    repeat (3) @(negedge clk);
    tick(4);
    check("R6 requalify", std_q, 0);
    tick(1);
    check("R6 requalified", std_q, 1);
    set_est(0); tick(3);
  endtask

  task automatic t_irq;
    @(negedge clk) trig_n = 0;
    #1 check("R7 trig", irq_n, 0);
    @(negedge clk) trig_n = 1; rdy_n = 0;
    #1 check("R7 rdy", irq_n, 0);
    @(negedge clk) rdy_n = 1;
    #1 check("R7 none", irq_n, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_sync; t_short; t_qualify; t_dropout; t_restart;
    t_cfg; t_disable; t_pd; t_irq;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule